// File: doc/BRIEF.md
# Page Write Buffer and Commit Controller

This block sits behind the bit-level serial front-end of a 512-word by 8-bit non-volatile memory model. The front-end hands it decoded events: the start of a transaction, a matched write-type device address carrying the memory page bit, each received byte, and the end of the transaction. The block builds a 9-bit word address from the page bit (address bit 8) and the first received byte (address bits 7..0). It then gathers the following data bytes into a 16-entry page buffer. After each byte only the low four address bits advance, so the pointer wraps inside the same 16-byte row.

The array is left alone until the transaction ends. On the end event, and only if at least one data byte was loaded and the write-protect input is low, the block enters a busy window of a fixed number of clocks. During the first 16 clocks of this window it writes the loaded buffer entries into the on-chip array, walking from entry 0 to entry 15 and skipping entries that were never loaded. While busy it ignores every front-end event and permits no acknowledges. A registered read port lets the surrounding model fetch array contents.

Top module: `page_commit_ctrl`

## Requirements
- R1: While reset is low at a clock edge, busy_o, ack_o and mem_we_o are all low after that edge, and every array word reads back as 0x00.
- R2: The page bit sampled with hdr_i becomes address bit 8 and the first byte after it becomes address bits 7..0. The first data byte is stored at that address.
- R3: Each word-address byte and each data byte accepted in a write sequence produces ack_o high for exactly the one cycle after the byte is presented. A byte outside a write sequence (no start and hdr_i first) produces no ack_o.
- R4: After each data byte, address bits 3..0 increment modulo 16 and bits 8..4 stay fixed, so a 16-byte burst that starts mid-row wraps to the row start.
- R5: When more than 16 data bytes arrive, later bytes overwrite the buffered entries they wrap onto. The last value given to each location is the one committed.
- R6: The array is not written before stop_i. busy_o rises in the cycle after a qualifying stop_i.
- R7: busy_o stays high for exactly WRITE_CYCLES consecutive cycles.
- R8: Only buffer entries loaded since the last start_i are written. Other words of the row keep their earlier values, and the number of array write cycles equals the number of distinct loaded entries.
- R9: A stop_i that comes before any complete data byte starts no busy window and writes nothing.
- R10: With wp_i high at stop_i, no busy window starts and the array is unchanged, although the bytes of the sequence are still acknowledged.
- R11: While busy_o is high, start_i, hdr_i, rx_valid_i and stop_i are ignored. No ack_o is given, no new sequence begins, and a stop_i does not start another window.
- R12: mem_we_o is high only while busy_o is high. Within one window every write address lies in the captured row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start of a bus transaction (one-cycle pulse) |
| hdr_i | input | 1 | Write-type device address matched (one-cycle pulse) |
| page_bit_i | input | 1 | Page bit from the device address, valid with hdr_i |
| rx_valid_i | input | 1 | A received byte is presented (one-cycle pulse) |
| rx_byte_i | input | 8 | Received byte value |
| stop_i | input | 1 | End of a bus transaction (one-cycle pulse) |
| wp_i | input | 1 | Write protect; high blocks the commit of the whole array |
| rd_addr_i | input | 9 | Array read address |
| busy_o | output | 1 | Internally timed write window in progress |
| ack_o | output | 1 | Acknowledge permitted for the byte presented in the previous cycle |
| mem_we_o | output | 1 | Array write strobe |
| mem_addr_o | output | 9 | Array write address |
| mem_wdata_o | output | 8 | Array write data |
| rd_data_o | output | 8 | Array read data, registered one cycle after rd_addr_i |

## Verification
On every cycle the assertions check four things: the busy window has exact length, a window opens only after an unprotected stop, array writes occur only inside a window and stay in one row, and no acknowledge follows a busy cycle. The address arithmetic needs the bench's scenarios: the row wrap, last-value-wins overflow, partial-page masking, and the protected or data-less stop. Those scenarios read the array back through the read port and compare against the expected page images.

// File: rtl/pcc_pkg.sv
// Shared sizes and types for the page write buffer and commit controller.
// Assumes a 512 x 8 array split into 32 rows of 16 bytes.
package pcc_pkg;
    localparam int ADDR_W     = 9;
    localparam int DATA_W     = 8;
    localparam int PAGE_BYTES = 16;
    localparam int IDX_W      = $clog2(PAGE_BYTES);
    localparam int ROW_W      = ADDR_W - IDX_W;
    localparam int DEPTH      = 1 << ADDR_W;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HDR   = 2'd1,
        ST_WADDR = 2'd2,
        ST_DATA  = 2'd3
    } seq_state_t;
endpackage

// File: rtl/page_addr_ctr.sv
// Word address register with in-row increment.
// Bit 8 loads from the page bit, bits 7..0 from the word-address byte.
// A step advances only the in-row index, so the pointer wraps inside its row.
// Assumes at most one of the load/step controls is active per cycle.
module page_addr_ctr
    import pcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_hi,
    input  logic              page_bit,
    input  logic              load_lo,
    input  logic [DATA_W-1:0] lo_byte,
    input  logic              step,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] addr_q;

    // Load or advance the address; the row bits never change on a step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load_hi) begin
            addr_q[ADDR_W-1] <= page_bit;
        end else if (load_lo) begin
            addr_q[DATA_W-1:0] <= lo_byte;
        end else if (step) begin
            addr_q[IDX_W-1:0] <= addr_q[IDX_W-1:0] + IDX_W'(1);
        end
    end

    assign addr = addr_q;
endmodule

// File: rtl/page_buf.sv
// Sixteen-entry page buffer with a per-entry loaded flag.
// A clear drops all flags; a write stores a byte and sets its flag.
// Read side is combinational, indexed by the commit walker.
module page_buf
    import pcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_loaded,
    output logic              any_loaded
);
    logic [PAGE_BYTES*DATA_W-1:0] data_flat;
    logic [PAGE_BYTES-1:0]        loaded;

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        logic [DATA_W-1:0] slot_q;
        logic              flag_q;

        // Hold one buffered byte and its loaded flag.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q <= '0;
                flag_q <= 1'b0;
            end else if (clr) begin
                flag_q <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                slot_q <= wr_data;
                flag_q <= 1'b1;
            end
        end

        assign data_flat[g*DATA_W +: DATA_W] = slot_q;
        assign loaded[g] = flag_q;
    end

    // Select the entry addressed by the commit walker.
    always_comb begin
        rd_data   = '0;
        rd_loaded = 1'b0;
        for (int i = 0; i < PAGE_BYTES; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_data   = data_flat[i*DATA_W +: DATA_W];
                rd_loaded = loaded[i];
            end
        end
    end

    assign any_loaded = |loaded;
endmodule

// File: rtl/commit_seq.sv
// Timed busy window and commit walker.
// A launch opens a window of WRITE_CYCLES clocks; the first PAGE_BYTES
// clocks of it present buffer indices 0..15 in order.
// Assumes WRITE_CYCLES >= PAGE_BYTES.
module commit_seq
    import pcc_pkg::*;
#(
    parameter int WRITE_CYCLES = 500000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             launch,
    output logic             busy,
    output logic             walking,
    output logic [IDX_W-1:0] idx
);
    localparam int CNT_W = $clog2(WRITE_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;

    // Run the busy window counter from launch to its last cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (!busy_q) begin
            if (launch) begin
                busy_q <= 1'b1;
                cnt_q  <= '0;
            end
        end else if (cnt_q == CNT_W'(WRITE_CYCLES - 1)) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign busy    = busy_q;
    assign walking = busy_q && (cnt_q < CNT_W'(PAGE_BYTES));
    assign idx     = cnt_q[IDX_W-1:0];
endmodule

// File: rtl/word_array.sv
// Synchronous register array, one write port and one registered read port.
// Clears to zero on reset so the model starts from a known image.
module word_array
    import pcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [DATA_W-1:0] rd_q;

    // Store written words and register the read word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
            rd_q <= '0;
        end else begin
            if (we) begin
                mem_q[waddr] <= wdata;
            end
            rd_q <= mem_q[raddr];
        end
    end

    assign rdata = rd_q;
endmodule

// File: rtl/page_commit_ctrl.sv
// Page write buffer and commit controller (top).
// Tracks a write sequence (start, header, word address, data bytes),
// buffers up to one page of data, and on stop commits the loaded entries
// to the array inside a fixed busy window. Write protect blocks the commit.
// Assumes the front-end raises at most one event input per cycle.
module page_commit_ctrl
    import pcc_pkg::*;
#(
    parameter int WRITE_CYCLES = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              hdr_i,
    input  logic              page_bit_i,
    input  logic              rx_valid_i,
    input  logic [DATA_W-1:0] rx_byte_i,
    input  logic              stop_i,
    input  logic              wp_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic              busy_o,
    output logic              ack_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic [DATA_W-1:0] rd_data_o
);
    seq_state_t        state_q;
    logic              ack_q;
    logic              busy;
    logic              walking;
    logic [IDX_W-1:0]  walk_idx;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] buf_byte;
    logic              buf_loaded;
    logic              any_loaded;
    logic              live;
    logic              load_hi;
    logic              load_lo;
    logic              data_wr;
    logic              buf_clr;
    logic              launch;
    logic              arr_we;
    logic [ADDR_W-1:0] arr_waddr;

    assign live    = !busy && !start_i && !stop_i;
    assign load_hi = live && (state_q == ST_HDR) && hdr_i;
    assign load_lo = live && (state_q == ST_WADDR) && rx_valid_i;
    assign data_wr = live && (state_q == ST_DATA) && rx_valid_i;
    assign buf_clr = !busy && start_i;
    assign launch  = !busy && stop_i && !start_i && (state_q == ST_DATA)
                     && any_loaded && !wp_i;

    // Advance the write-sequence state; frozen while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else if (!busy) begin
            if (start_i) begin
                state_q <= ST_HDR;
            end else if (stop_i) begin
                state_q <= ST_IDLE;
            end else if (load_hi) begin
                state_q <= ST_WADDR;
            end else if (load_lo) begin
                state_q <= ST_DATA;
            end
        end
    end

    // Register the acknowledge permit for accepted address and data bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
        end else begin
            ack_q <= load_lo || data_wr;
        end
    end

    page_addr_ctr u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_hi  (load_hi),
        .page_bit (page_bit_i),
        .load_lo  (load_lo),
        .lo_byte  (rx_byte_i),
        .step     (data_wr),
        .addr     (addr)
    );

    page_buf u_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (buf_clr),
        .wr_en      (data_wr),
        .wr_idx     (addr[IDX_W-1:0]),
        .wr_data    (rx_byte_i),
        .rd_idx     (walk_idx),
        .rd_data    (buf_byte),
        .rd_loaded  (buf_loaded),
        .any_loaded (any_loaded)
    );

    commit_seq #(
        .WRITE_CYCLES (WRITE_CYCLES)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch  (launch),
        .busy    (busy),
        .walking (walking),
        .idx     (walk_idx)
    );

    assign arr_we    = walking && buf_loaded;
    assign arr_waddr = {addr[ADDR_W-1:IDX_W], walk_idx};

    word_array u_arr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (arr_we),
        .waddr (arr_waddr),
        .wdata (buf_byte),
        .raddr (rd_addr_i),
        .rdata (rd_data_o)
    );

    assign busy_o      = busy;
    assign ack_o       = ack_q;
    assign mem_we_o    = arr_we;
    assign mem_addr_o  = arr_waddr;
    assign mem_wdata_o = buf_byte;
endmodule

// File: rtl/page_commit_chk.sv
// Property checker for page_commit_ctrl, attached by bind.
// Watches window length, window entry, write strobe placement and acks.
module page_commit_chk
    import pcc_pkg::*;
#(
    parameter int WRITE_CYCLES = 500000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stop_i,
    input logic              wp_i,
    input logic              rx_valid_i,
    input logic              busy_o,
    input logic              ack_o,
    input logic              mem_we_o,
    input logic [ADDR_W-1:0] mem_addr_o
);
    logic [31:0] blen_q;

    // Count consecutive busy cycles for the window length check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blen_q <= '0;
        end else if (busy_o) begin
            blen_q <= blen_q + 32'd1;
        end else begin
            blen_q <= '0;
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!busy_o && !ack_o && !mem_we_o));

    assert_ack_follows_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> $past(rx_valid_i));

    assert_window_from_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(stop_i));

    assert_window_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (blen_q == 32'(WRITE_CYCLES)));

    assert_window_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (blen_q < 32'(WRITE_CYCLES)));

    assert_protect_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> !$past(wp_i));

    assert_no_ack_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy_o) |-> !ack_o);

    assert_we_in_window_R12: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> busy_o);

    assert_row_steady_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && $past(mem_we_o)) |->
            (mem_addr_o[ADDR_W-1:IDX_W] == $past(mem_addr_o[ADDR_W-1:IDX_W])));
endmodule

bind page_commit_ctrl page_commit_chk #(
    .WRITE_CYCLES (WRITE_CYCLES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .stop_i     (stop_i),
    .wp_i       (wp_i),
    .rx_valid_i (rx_valid_i),
    .busy_o     (busy_o),
    .ack_o      (ack_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o)
);

// File: tb/page_commit_ctrl_test.sv
// Bench for page_commit_ctrl: a vector table of byte writes, then
// directed tests for reset, row wrap, overflow, partial page, protect,
// data-less stop and bus activity during the busy window.
module page_commit_ctrl_test;
    localparam int W = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       hdr_i = 1'b0;
    logic       page_bit_i = 1'b0;
    logic       rx_valid_i = 1'b0;
    logic [7:0] rx_byte_i = '0;
    logic       stop_i = 1'b0;
    logic       wp_i = 1'b0;
    logic [8:0] rd_addr_i = '0;
    logic       busy_o;
    logic       ack_o;
    logic       mem_we_o;
    logic [8:0] mem_addr_o;
    logic [7:0] mem_wdata_o;
    logic [7:0] rd_data_o;

    int errors = 0;
    int checks = 0;
    int stray_we = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    page_commit_ctrl #(.WRITE_CYCLES(W)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .hdr_i(hdr_i),
        .page_bit_i(page_bit_i), .rx_valid_i(rx_valid_i), .rx_byte_i(rx_byte_i),
        .stop_i(stop_i), .wp_i(wp_i), .rd_addr_i(rd_addr_i), .busy_o(busy_o),
        .ack_o(ack_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .rd_data_o(rd_data_o)
    );

    // Vector table: {page bit, word address, data, expected read-back}.
    localparam logic [24:0] VEC [0:5] = '{
        {1'b0, 8'h00, 8'h3A, 8'h3A},
        {1'b0, 8'hFF, 8'hC5, 8'hC5},
        {1'b1, 8'h00, 8'h81, 8'h81},
        {1'b1, 8'hFF, 8'h7E, 8'h7E},
        {1'b0, 8'h2B, 8'h99, 8'h99},
        {1'b1, 8'hA7, 8'h42, 8'h42}
    };

    // Count array writes seen outside a busy window (R12).
    always @(negedge clk) begin
        if (rst_n && mem_we_o && !busy_o) stray_we++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_start();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    task automatic do_hdr(input logic pb);
        @(negedge clk); hdr_i = 1'b1; page_bit_i = pb;
        @(negedge clk); hdr_i = 1'b0;
    endtask

    task automatic do_rx(input logic [7:0] b, output logic got);
        @(negedge clk); rx_valid_i = 1'b1; rx_byte_i = b;
        @(negedge clk); got = ack_o; rx_valid_i = 1'b0;
    endtask

    task automatic read_mem(input logic [8:0] a, output logic [7:0] d);
        @(negedge clk); rd_addr_i = a;
        @(negedge clk); d = rd_data_o;
    endtask

    task automatic stop_commit(input logic [4:0] row, output logic rose,
                               output int len, output int writes);
        @(negedge clk); stop_i = 1'b1;
        @(negedge clk); stop_i = 1'b0;
        rose = busy_o; len = 0; writes = 0;
        while (busy_o && len < 100000) begin
            len++;
            if (mem_we_o) begin
                writes++;
                check(mem_addr_o[8:4] == row, "R12 row", mem_addr_o[8:4], row);
            end
            @(negedge clk);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic       got;
        logic       rose;
        logic [7:0] d;
        int         len;
        int         writes;

        repeat (3) @(negedge clk);
        // R1: quiet outputs and cleared array during reset
        check(!busy_o && !ack_o && !mem_we_o, "R1 outputs", {busy_o, ack_o, mem_we_o}, 0);
        rst_n = 1'b1;
        read_mem(9'h1FF, d);
        check(d == 8'h00, "R1 array", d, 0);

        // Vector loop: single-byte writes (R2, R3, R6, R7)
        for (int v = 0; v < 6; v++) begin
            do_start();
            do_hdr(VEC[v][24]);
            do_rx(VEC[v][23:16], got);
            check(got, "R3 ack waddr", got, 1);
            do_rx(VEC[v][15:8], got);
            check(got, "R3 ack data", got, 1);
            @(negedge clk);
            check(!ack_o, "R3 ack one cycle", ack_o, 0);
            stop_commit({VEC[v][24], VEC[v][23:20]}, rose, len, writes);
            check(rose, "R6 busy after stop", rose, 1);
            check(len == W, "R7 window length", len, W);
            read_mem({VEC[v][24], VEC[v][23:16]}, d);
            check(d == VEC[v][7:0], "R2 read back", d, VEC[v][7:0]);
        end

        // R4: full burst from mid-row wraps to row start; R6 no early write
        do_start(); do_hdr(1'b1); do_rx(8'h3C, got);
        for (int k = 0; k < 16; k++) do_rx(8'hA0 + 8'(k), got);
        read_mem(9'h13C, d);
        check(d == 8'h00, "R6 no write before stop", d, 0);
        stop_commit(5'h13, rose, len, writes);
        check(rose && writes == 16, "R6 commit writes", writes, 16);
        for (int k = 0; k < 16; k++) begin
            read_mem(9'h130 + 9'((12 + k) % 16), d);
            check(d == 8'hA0 + 8'(k), "R4 wrap", d, 8'hA0 + 8'(k));
        end

        // R5: 18 bytes; the last two overwrite entries 0 and 1
        do_start(); do_hdr(1'b0); do_rx(8'h50, got);
        for (int k = 0; k < 18; k++) do_rx(8'h10 + 8'(k), got);
        stop_commit(5'h05, rose, len, writes);
        check(writes == 16, "R5 write count", writes, 16);
        read_mem(9'h050, d); check(d == 8'h20, "R5 loc0 last wins", d, 8'h20);
        read_mem(9'h051, d); check(d == 8'h21, "R5 loc1 last wins", d, 8'h21);
        read_mem(9'h052, d); check(d == 8'h12, "R5 loc2", d, 8'h12);

        // R8: prefill a row, then partial write of three bytes
        do_start(); do_hdr(1'b0); do_rx(8'h60, got);
        for (int k = 0; k < 16; k++) do_rx(8'h70 + 8'(k), got);
        stop_commit(5'h06, rose, len, writes);
        do_start(); do_hdr(1'b0); do_rx(8'h65, got);
        do_rx(8'hE1, got); do_rx(8'hE2, got); do_rx(8'hE3, got);
        stop_commit(5'h06, rose, len, writes);
        check(writes == 3, "R8 write count", writes, 3);
        read_mem(9'h064, d); check(d == 8'h74, "R8 below untouched", d, 8'h74);
        read_mem(9'h066, d); check(d == 8'hE2, "R8 loaded", d, 8'hE2);
        read_mem(9'h068, d); check(d == 8'h78, "R8 above untouched", d, 8'h78);

        // R9: stop after the word address only
        do_start(); do_hdr(1'b0); do_rx(8'h40, got);
        stop_commit(5'h04, rose, len, writes);
        check(!rose && writes == 0, "R9 no window", rose, 0);
        read_mem(9'h040, d); check(d == 8'h00, "R9 array unchanged", d, 0);

        // R10: protected sequence is acked but not committed
        do_start(); do_hdr(1'b1); do_rx(8'h02, got);
        do_rx(8'h55, got); check(got, "R10 ack under protect", got, 1);
        do_rx(8'h66, got);
        wp_i = 1'b1;
        stop_commit(5'h10, rose, len, writes);
        check(!rose, "R10 no window", rose, 0);
        wp_i = 1'b0;
        read_mem(9'h102, d); check(d == 8'h00, "R10 array unchanged", d, 0);

        // R3: byte outside a sequence gets no ack
        do_rx(8'h11, got);
        check(!got, "R3 no ack outside sequence", got, 0);

        // R11: bus events during the busy window are ignored
        do_start(); do_hdr(1'b0); do_rx(8'h90, got); do_rx(8'h11, got);
        @(negedge clk); stop_i = 1'b1;
        @(negedge clk); stop_i = 1'b0;
        check(busy_o, "R6 busy raised", busy_o, 1);
        do_start(); do_hdr(1'b1); do_rx(8'hC0, got);
        check(!got, "R11 no ack while busy", got, 0);
        do_rx(8'h77, got);
        check(!got, "R11 no data ack while busy", got, 0);
        @(negedge clk); stop_i = 1'b1;
        @(negedge clk); stop_i = 1'b0;
        len = 0;
        while (busy_o && len < 1000) begin len++; @(negedge clk); end
        repeat (3) @(negedge clk);
        check(!busy_o, "R11 no second window", busy_o, 0);
        read_mem(9'h1C0, d); check(d == 8'h00, "R11 ignored bytes", d, 0);
        read_mem(9'h090, d); check(d == 8'h11, "R11 first write kept", d, 8'h11);

        check(stray_we == 0, "R12 stray writes", stray_we, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule